// File: doc/BRIEF.md
# ADC Conversion Trigger and Command Controller

This block decides when an analog-to-digital converter starts a single conversion, and it holds the command state of the converter's sample interface. A 5-bit source index picks one line of a 32-line event bus. The lines may change at any time relative to the local clock, so every line passes through a synchronizer before it is used. A polarity bit sets whether a rising or a falling transition of the chosen line starts a conversion. Software can also start one conversion directly with a strobe. Four source codes (7 through 10) never produce an event-driven start. Two of these are the codes meant for manual operation, and the other two are reserved.

The control word carries a 2-bit command: disable, enable or flush. A flush write sends a one-cycle clear pulse to the downstream sample FIFO. Software must then write enable or disable, waiting at least two clock cycles first. Starts are issued only while the command is enable. The stored fields read back exactly as they were written, including the unsupported command code 2.

Top module: `adc_start_ctrl`

## Requirements
- R1: After a synchronous reset the command is disable, the source index and polarity are 0, `conv_start` and `fifo_flush` are low, and the readback is 0.
- R2: The control word holds the command in bits [1:0], the source index in bits [12:8] and the polarity in bit 13. The readback returns exactly these fields as written, with bits [7:2] reading 0. A command of 2 reads back as 2.
- R3: With polarity 0, a low-to-high transition on the selected event line makes `conv_start` high for one cycle, on the third rising clock edge after the change.
- R4: With polarity 1, a high-to-low transition on the selected line starts a conversion, and a low-to-high transition does not.
- R5: Source codes 7, 8, 9 and 10 never produce an event-driven start, whatever the event bus does.
- R6: A trigger write with data 1 while enabled makes `conv_start` high for exactly the cycle after that write. A trigger write with data 0 produces no start.
- R7: No start, whether event-driven or manual, is issued while the command is disable, 2 or flush.
- R8: Each control write with command 3 makes `fifo_flush` high for exactly one cycle. While the command remains flush, no start is issued.
- R9: A control write that changes the source index or the polarity clears the edge history, so the switch itself produces no start even when the new line sits at a different level.
- R10: `if_enable` is high exactly when the stored command is enable (1).
- R11: A selected line that stays at its active level yields only one start for the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_bus | input | 32 | Asynchronous event lines |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wr_data | input | 14 | Control word write data |
| trig_wr_en | input | 1 | Manual trigger write strobe |
| trig_wr_data | input | 1 | Manual trigger data (1 = start) |
| ctl_rd_data | output | 14 | Control word readback |
| conv_start | output | 1 | One-cycle conversion start pulse |
| if_enable | output | 1 | Interface enable level |
| fifo_flush | output | 1 | One-cycle FIFO flush pulse |

## Verification
The bench builds the block with its default two synchronizer stages and a 5-bit source index. This makes all 32 event lines selectable, including the four quiet codes and the top code 31. With the two-stage synchronizer, the three-edge start latency can be checked cycle by exact cycle. The width also lets the bench hold a neighbouring line at a different level, so it can show that switching the source leaves no edge behind.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    localparam int SRC_W    = 5;
    localparam int EVT_W    = 1 << SRC_W;
    localparam int CTL_W    = 14;
    localparam int CMD_LSB  = 0;
    localparam int SRC_LSB  = 8;
    localparam int POL_BIT  = 13;
    localparam int QUIET_LO = 7;
    localparam int QUIET_HI = 10;

    typedef enum logic [1:0] {
        CMD_DIS   = 2'd0,
        CMD_EN    = 2'd1,
        CMD_RSVD  = 2'd2,
        CMD_FLUSH = 2'd3
    } cmd_e;

    typedef struct packed {
        logic             pol;
        logic [SRC_W-1:0] src;
        cmd_e             cmd;
    } ctl_t;

    function automatic logic src_is_quiet(input logic [SRC_W-1:0] s);
        return (int'(s) >= QUIET_LO) && (int'(s) <= QUIET_HI);
    endfunction

    function automatic ctl_t unpack_ctl(input logic [CTL_W-1:0] w);
        ctl_t c;
        c.pol = w[POL_BIT];
        c.src = w[SRC_LSB +: SRC_W];
        c.cmd = cmd_e'(w[CMD_LSB +: 2]);
        return c;
    endfunction

    function automatic logic [CTL_W-1:0] pack_ctl(input ctl_t c);
        logic [CTL_W-1:0] w;
        w = '0;
        w[POL_BIT]           = c.pol;
        w[SRC_LSB +: SRC_W]  = c.src;
        w[CMD_LSB +: 2]      = c.cmd;
        return w;
    endfunction

endpackage

// File: rtl/adc_evt_sync.sv
module adc_evt_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= async_in;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/adc_ctl_regs.sv
module adc_ctl_regs
    import adc_trig_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output ctl_t             ctl,
    output logic             flush_pulse,
    output logic             hist_clr
);
    ctl_t nxt;
    logic unused_bits;

    assign nxt         = unpack_ctl(wr_data);
    assign unused_bits = ^wr_data[SRC_LSB-1:2];
    assign hist_clr    = wr_en && ((nxt.src != ctl.src) || (nxt.pol != ctl.pol));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl         <= '{pol: 1'b0, src: '0, cmd: CMD_DIS};
            flush_pulse <= 1'b0;
        end else begin
            flush_pulse <= wr_en && (nxt.cmd == CMD_FLUSH);
            if (wr_en) ctl <= nxt;
        end
    end
endmodule

// File: rtl/adc_edge_det.sv
module adc_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic fall_sel,
    input  logic clr,
    input  logic blocked,
    output logic hit
);
    logic prev;
    logic valid;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            prev  <= 1'b0;
            valid <= 1'b0;
        end else begin
            prev  <= lvl;
            valid <= 1'b1;
        end
    end

    assign hit = valid && !blocked &&
                 (fall_sel ? (prev && !lvl) : (!prev && lvl));
endmodule

// File: rtl/adc_start_ctrl.sv
module adc_start_ctrl
    import adc_trig_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_W-1:0] evt_bus,
    input  logic             ctl_wr_en,
    input  logic [CTL_W-1:0] ctl_wr_data,
    input  logic             trig_wr_en,
    input  logic             trig_wr_data,
    output logic [CTL_W-1:0] ctl_rd_data,
    output logic             conv_start,
    output logic             if_enable,
    output logic             fifo_flush
);
    ctl_t             ctl;
    logic             hist_clr;
    logic [EVT_W-1:0] evt_sync;
    logic             sel_lvl;
    logic             edge_hit;
    logic             man_req;
    logic             start_q;

    adc_ctl_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (ctl_wr_en),
        .wr_data     (ctl_wr_data),
        .ctl         (ctl),
        .flush_pulse (fifo_flush),
        .hist_clr    (hist_clr)
    );

    adc_evt_sync #(.WIDTH(EVT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (evt_bus),
        .sync_out (evt_sync)
    );

    assign sel_lvl = evt_sync[ctl.src];

    adc_edge_det u_edge (
        .clk      (clk),
        .rst      (rst),
        .lvl      (sel_lvl),
        .fall_sel (ctl.pol),
        .clr      (hist_clr),
        .blocked  (src_is_quiet(ctl.src)),
        .hit      (edge_hit)
    );

    assign man_req   = trig_wr_en && trig_wr_data;
    assign if_enable = (ctl.cmd == CMD_EN);

    always_ff @(posedge clk) begin
        if (rst) start_q <= 1'b0;
        else     start_q <= if_enable && (edge_hit || man_req);
    end

    assign conv_start  = start_q;
    assign ctl_rd_data = pack_ctl(ctl);
endmodule

// File: rtl/adc_start_ctrl_chk.sv
module adc_start_ctrl_chk
    import adc_trig_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ctl_wr_en,
    input logic [CTL_W-1:0] ctl_wr_data,
    input logic             trig_wr_en,
    input logic             trig_wr_data,
    input logic [CTL_W-1:0] ctl_rd_data,
    input logic             conv_start,
    input logic             if_enable,
    input logic             fifo_flush
);
    // R7
    start_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> $past(if_enable));

    // R8
    flush_from_write_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_flush |-> $past(ctl_wr_en && ctl_wr_data[1:0] == 2'd3));

    // R8
    flush_state_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_flush |-> (ctl_rd_data[1:0] == 2'd3 && !if_enable));

    // R5
    quiet_src_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_start && !$past(trig_wr_en && trig_wr_data))
            |-> !src_is_quiet($past(ctl_rd_data[SRC_LSB +: SRC_W])));

    // R6
    manual_start_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_wr_en && trig_wr_data && if_enable) |=> conv_start);

    // R10
    enable_level_chk: assert property (@(posedge clk) disable iff (rst)
        if_enable == (ctl_rd_data[1:0] == 2'd1));
endmodule

bind adc_start_ctrl adc_start_ctrl_chk u_chk (.*);

// File: tb/test_adc_start_ctrl.sv
module test_adc_start_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] evt_bus = '0;
    logic        ctl_wr_en = 1'b0;
    logic [13:0] ctl_wr_data = '0;
    logic        trig_wr_en = 1'b0;
    logic        trig_wr_data = 1'b0;
    logic [13:0] ctl_rd_data;
    logic        conv_start;
    logic        if_enable;
    logic        fifo_flush;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    adc_start_ctrl i_adc_start_ctrl (.*);

    // control words written by the table loop (bits 7:2 deliberately dirty)
    localparam logic [13:0] VEC [8] = '{
        14'h0001, 14'h2A01, 14'h1F7E, 14'h3FFD,
        14'h0902, 14'h15FC, 14'h2003, 14'h0000
    };

    function automatic logic [13:0] ctl_word(int src, bit pol, int cmd);
        return {pol, 5'(src), 6'b0, 2'(cmd)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr_ctl(logic [13:0] w);
        ctl_wr_en = 1'b1; ctl_wr_data = w;
        tick();
        ctl_wr_en = 1'b0;
    endtask

    task automatic wr_trig(bit v);
        trig_wr_en = 1'b1; trig_wr_data = v;
        tick();
        trig_wr_en = 1'b0;
    endtask

    task automatic count_starts(int n, output int c);
        c = 0;
        repeat (n) begin
            tick();
            if (conv_start) c++;
        end
    endtask

    initial begin
        int c;
        repeat (3) tick();
        // R1 reset state
        check("R1 readback", ctl_rd_data, 0);
        check("R1 start", conv_start, 0);
        check("R1 flush", fifo_flush, 0);
        check("R1 enable", if_enable, 0);
        rst = 1'b0;
        tick();

        // R2 / R10 / R8 table walk
        foreach (VEC[i]) begin
            wr_ctl(VEC[i]);
            check("R2 readback", ctl_rd_data, VEC[i] & 14'h3F03);
            check("R10 enable", if_enable, VEC[i][1:0] == 2'd1);
            check("R8 flush pulse", fifo_flush, VEC[i][1:0] == 2'd3);
        end

        // R3 rising edge, exact latency
        wr_ctl(ctl_word(3, 0, 1));
        repeat (4) tick();
        evt_bus[3] = 1'b1;
        tick(); tick();
        check("R3 not yet", conv_start, 0);
        tick();
        check("R3 start", conv_start, 1);
        tick();
        check("R3 one cycle", conv_start, 0);
        // R11 held high: no further starts
        count_starts(10, c);
        check("R11 held level", c, 0);
        evt_bus[3] = 1'b0;
        count_starts(6, c);
        check("R3 falling ignored", c, 0);

        // R4 falling edge with polarity 1
        evt_bus[6] = 1'b1;
        wr_ctl(ctl_word(6, 1, 1));
        count_starts(6, c);
        check("R4 switch quiet", c, 0);
        evt_bus[6] = 1'b0;
        count_starts(6, c);
        check("R4 falling start", c, 1);
        evt_bus[6] = 1'b1;
        count_starts(6, c);
        check("R4 rising ignored", c, 0);

        // R5 quiet codes
        for (int s = 7; s <= 10; s++) begin
            wr_ctl(ctl_word(s, 0, 1));
            evt_bus = '0;
            count_starts(4, c);
            evt_bus = '1;
            count_starts(6, c);
            check($sformatf("R5 code %0d", s), c, 0);
            evt_bus = '0;
            count_starts(6, c);
            check($sformatf("R5 code %0d fall", s), c, 0);
        end

        // R6 manual start on a no-event code
        wr_ctl(ctl_word(9, 0, 1));
        wr_trig(1'b1);
        check("R6 manual start", conv_start, 1);
        tick();
        check("R6 single cycle", conv_start, 0);
        wr_trig(1'b0);
        check("R6 zero write", conv_start, 0);
        count_starts(4, c);
        check("R6 zero write later", c, 0);

        // R7 no starts unless enabled: disable and code 2
        for (int cm = 0; cm <= 2; cm += 2) begin
            wr_ctl(ctl_word(31, 0, cm));
            check("R10 not enabled", if_enable, 0);
            evt_bus[31] = 1'b1;
            count_starts(6, c);
            wr_trig(1'b1);
            if (conv_start) c++;
            count_starts(3, c);
            check($sformatf("R7 cmd %0d", cm), c, 0);
            evt_bus[31] = 1'b0;
            count_starts(4, c);
        end

        // R8 flush: pulse once, no starts while held
        wr_ctl(ctl_word(31, 0, 3));
        check("R8 flush high", fifo_flush, 1);
        tick();
        check("R8 flush one cycle", fifo_flush, 0);
        evt_bus[31] = 1'b1;
        count_starts(6, c);
        wr_trig(1'b1);
        if (conv_start) c++;
        check("R8 no start while flush", c, 0);
        check("R8 flush stays low", fifo_flush, 0);
        evt_bus[31] = 1'b0;
        count_starts(4, c);
        wr_ctl(ctl_word(31, 0, 1));
        check("R10 enable after flush", if_enable, 1);
        check("R8 no pulse on enable", fifo_flush, 0);

        // R9 source switch to a line at a different level
        evt_bus[4] = 1'b0;
        evt_bus[5] = 1'b1;
        wr_ctl(ctl_word(4, 0, 1));
        count_starts(6, c);
        wr_ctl(ctl_word(5, 0, 1));
        if (conv_start) c++;
        count_starts(6, c);
        check("R9 switch no start", c, 0);
        evt_bus[5] = 1'b0;
        count_starts(5, c);
        evt_bus[5] = 1'b1;
        count_starts(6, c);
        check("R9 later edge fires", c, 1);
        // R9 polarity flip on a high line
        wr_ctl(ctl_word(5, 1, 1));
        count_starts(6, c);
        check("R9 polarity flip", c, 0);

        // R1 reset again mid-run
        rst = 1'b1;
        tick();
        check("R1 re-reset readback", ctl_rd_data, 0);
        check("R1 re-reset enable", if_enable, 0);
        rst = 1'b0;

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule